// File: doc/BRIEF.md
# Exception Entry Vector Generator

This block sits beside the processor's control state and turns a single exception request into the new program counter for the handler, the saved return address and the updated status and cause bits. A request arrives with a valid strobe, a 5-bit kind, a TLB no-match flag and a delay-slot flag. It comes with the current program counter and with the fields it needs from the status, cause, interrupt-control and exception-base registers. One clock edge later the block presents the handler address for one cycle and holds the updated state on its outputs.

Four entry classes are handled. General exceptions, including TLB refill, cache error and vectored interrupts, enter relative to a selectable base. Non-maskable interrupt and soft reset enter through the error vector. Debug-class events enter through the debug vector. A general exception that arrives while the exception-level bit is already set still redirects the program counter and records its code. It leaves the saved return address, the delay-slot bit and the exception level untouched.

Top module: `exc_vector_unit`

## Requirements
- R1: A general exception enters at base plus offset. The base is 0xBFC00200 when `stBev` is 1 and `excBase` with bits 9:0 cleared otherwise. The default offset is 0x180.
- R2: A TLB load (kind 2) or TLB store (kind 3) with `reqNoMatch`=1 and `stExl`=0 uses offset 0x000. With `stExl`=1 or `reqNoMatch`=0 the offset is 0x180.
- R3: An interrupt (kind 0) uses offset 0x180 when `causeIv`=0. With `causeIv`=1 it uses 0x200 when `stBev`=1 or `vecSpacing`=0. Otherwise it uses 0x200 + vector × (`vecSpacing` × 32).
- R4: With `extCtrlMode`=0 the vector is the bit index of the highest 1 in `causePend` AND `stIntMask`, or 0 when none is set. With `extCtrlMode`=1 the vector is the unmasked 8-bit `causePend` value.
- R5: A general exception writes its kind to `excCode`. The legal general kinds are 0 to 13, 15, 19, 20 and 30 (cache error). Error and debug kinds leave `excCode` unchanged.
- R6: With `stExl`=0 a general exception sets `epcOut` to the resume address and copies `reqInDelay` into `branchDelay`. It also sets `excLevel` and `kernelMode`. The resume address is `curPc`, or `curPc`-4 when `reqInDelay`=1.
- R7: With `stExl`=1 a general exception leaves `epcOut`, `branchDelay` and `excLevel` unchanged. It still produces its handler address and code.
- R8: Kind 28 (NMI) and kind 29 (soft reset) store the resume address in `errEpcOut`, set `errLevel`, `bootVec` and `kernelMode`, and enter at 0xBFC00000. With `stExl`=0 they also clear `branchDelay`.
- R9: Kind 31 (debug) stores the resume address in `dbgEpcOut`, sets `dbgMode` and `kernelMode`, and enters at 0xBFC00480.
- R10: A cache error (kind 30) uses offset 0x100 when `stBev`=1 and 0x20000100 otherwise.
- R11: `newPcValid` is 1 in exactly the cycle after a request with a legal kind. Requests with kinds 14, 16 to 18 and 21 to 27 are ignored and change no output.
- R12: After reset, `newPcValid`, `newPc`, all saved addresses, all status bits and `excCode` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Exception request strobe |
| reqKind | input | 5 | Exception kind |
| reqNoMatch | input | 1 | TLB lookup found no entry |
| reqInDelay | input | 1 | Faulting instruction is in a delay slot |
| curPc | input | 32 | Current program counter |
| stBev | input | 1 | Boot exception vector bit of status |
| stExl | input | 1 | Exception level bit of status |
| stIntMask | input | 8 | Interrupt mask bits of status |
| causeIv | input | 1 | Interrupt vector select bit of cause |
| causePend | input | 8 | Pending interrupt lines of cause |
| vecSpacing | input | 5 | Vector spacing field of interrupt control |
| extCtrlMode | input | 1 | External interrupt controller supplies the vector |
| excBase | input | 32 | Exception base register |
| newPcValid | output | 1 | Handler address valid, one cycle |
| newPc | output | 32 | Handler address |
| epcOut | output | 32 | Saved return address, general exceptions |
| errEpcOut | output | 32 | Saved return address, error class |
| dbgEpcOut | output | 32 | Saved return address, debug class |
| excLevel | output | 1 | Exception level set by this unit |
| errLevel | output | 1 | Error level set by this unit |
| bootVec | output | 1 | Boot vector bit set by error entry |
| kernelMode | output | 1 | Kernel mode forced |
| branchDelay | output | 1 | Branch-delay cause bit |
| dbgMode | output | 1 | Debug mode entered |
| excCode | output | 5 | Exception code for cause |

## Verification
The embedded properties check on every cycle the following: the handler strobe follows each legal request by one cycle and stays low after idle cycles, the saved return address and exception level hold while the exception level is set, and the error and debug entries land on their fixed vectors with their mode bits set. They also check that a taken exception with the level clear records the delay-adjusted return address. The handler offset arithmetic can only be shown by the bench's scenarios: base selection, the refill shortcut, vectored-interrupt priority and spacing, external-controller vectors and the cache-error offsets. The same holds for the exception code of each kind and for the way illegal kinds leave every output untouched.

// File: rtl/exc_vec_pkg.sv
package exc_vec_pkg;

  typedef enum logic [4:0] {
    KIND_INTR       = 5'd0,
    KIND_TLB_MOD    = 5'd1,
    KIND_TLB_LOAD   = 5'd2,
    KIND_TLB_STORE  = 5'd3,
    KIND_ADDR_LOAD  = 5'd4,
    KIND_ADDR_STORE = 5'd5,
    KIND_IBUS       = 5'd6,
    KIND_DBUS       = 5'd7,
    KIND_SYSCALL    = 5'd8,
    KIND_BREAK      = 5'd9,
    KIND_RSVD_INSN  = 5'd10,
    KIND_COP_UNUSE  = 5'd11,
    KIND_OVERFLOW   = 5'd12,
    KIND_TRAP       = 5'd13,
    KIND_FLOAT      = 5'd15,
    KIND_READ_INH   = 5'd19,
    KIND_EXEC_INH   = 5'd20,
    KIND_NMI        = 5'd28,
    KIND_SOFT_RST   = 5'd29,
    KIND_CACHE_ERR  = 5'd30,
    KIND_DEBUG      = 5'd31
  } excKind_e;

  typedef struct packed {
    logic       takeGen;
    logic       takeErr;
    logic       takeDbg;
    logic       isIntr;
    logic       isRefill;
    logic       isCacheErr;
    logic [4:0] code;
  } ctrlStrobes_t;

endpackage

// File: rtl/exc_vec_prio.sv
module exc_vec_prio #(
  parameter int LINES = 8,
  parameter int IDX_W = $clog2(LINES)
) (
  input  logic [LINES-1:0] lines,
  output logic [IDX_W-1:0] idx
);
  // Highest index wins: later iterations overwrite earlier ones.
  always_comb begin
    idx = '0;
    for (int i = 0; i < LINES; i++) begin
      if (lines[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/exc_vec_ctrl.sv
module exc_vec_ctrl
  import exc_vec_pkg::*;
(
  input  logic         reqValid,
  input  logic [4:0]   reqKind,
  input  logic         reqNoMatch,
  input  logic         stExl,
  output ctrlStrobes_t strobes
);
  logic legalGen;

  always_comb begin
    case (reqKind)
      KIND_INTR, KIND_TLB_MOD, KIND_TLB_LOAD, KIND_TLB_STORE,
      KIND_ADDR_LOAD, KIND_ADDR_STORE, KIND_IBUS, KIND_DBUS,
      KIND_SYSCALL, KIND_BREAK, KIND_RSVD_INSN, KIND_COP_UNUSE,
      KIND_OVERFLOW, KIND_TRAP, KIND_FLOAT, KIND_READ_INH,
      KIND_EXEC_INH, KIND_CACHE_ERR: legalGen = 1'b1;
      default:                       legalGen = 1'b0;
    endcase
  end

  always_comb begin
    strobes            = '0;
    strobes.takeGen    = reqValid && legalGen;
    strobes.takeErr    = reqValid && (reqKind == KIND_NMI || reqKind == KIND_SOFT_RST);
    strobes.takeDbg    = reqValid && (reqKind == KIND_DEBUG);
    strobes.isIntr     = (reqKind == KIND_INTR);
    strobes.isRefill   = reqNoMatch && !stExl &&
                         (reqKind == KIND_TLB_LOAD || reqKind == KIND_TLB_STORE);
    strobes.isCacheErr = (reqKind == KIND_CACHE_ERR);
    strobes.code       = reqKind;
  end
endmodule

// File: rtl/exc_vec_datapath.sv
module exc_vec_datapath
  import exc_vec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINES  = 8,
  parameter int SPC_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  ctrlStrobes_t      strobes,
  input  logic              reqInDelay,
  input  logic [ADDR_W-1:0] curPc,
  input  logic              stBev,
  input  logic              stExl,
  input  logic [LINES-1:0]  stIntMask,
  input  logic              causeIv,
  input  logic [LINES-1:0]  causePend,
  input  logic [SPC_W-1:0]  vecSpacing,
  input  logic              extCtrlMode,
  input  logic [ADDR_W-1:0] excBase,
  output logic              newPcValid,
  output logic [ADDR_W-1:0] newPc,
  output logic [ADDR_W-1:0] epcOut,
  output logic [ADDR_W-1:0] errEpcOut,
  output logic [ADDR_W-1:0] dbgEpcOut,
  output logic              excLevel,
  output logic              errLevel,
  output logic              bootVec,
  output logic              kernelMode,
  output logic              branchDelay,
  output logic              dbgMode,
  output logic [4:0]        excCode
);
  localparam int IDX_W = $clog2(LINES);
  localparam int SLOT_SHIFT = 5;
  localparam logic [ADDR_W-1:0] BOOT_GEN_BASE = ADDR_W'(32'hBFC0_0200);
  localparam logic [ADDR_W-1:0] ERR_VECTOR    = ADDR_W'(32'hBFC0_0000);
  localparam logic [ADDR_W-1:0] DBG_VECTOR    = ADDR_W'(32'hBFC0_0480);
  localparam logic [ADDR_W-1:0] OFS_GENERAL   = ADDR_W'(32'h180);
  localparam logic [ADDR_W-1:0] OFS_REFILL    = '0;
  localparam logic [ADDR_W-1:0] OFS_INTR      = ADDR_W'(32'h200);
  localparam logic [ADDR_W-1:0] OFS_CACHE_BEV = ADDR_W'(32'h100);
  localparam logic [ADDR_W-1:0] OFS_CACHE_RAM = ADDR_W'(32'h2000_0100);
  localparam logic [ADDR_W-1:0] BASE_MASK     = ~ADDR_W'(32'h3FF);

  logic [LINES-1:0]  maskedPend;
  logic [IDX_W-1:0]  hiIdx;
  logic [LINES-1:0]  vecNum;
  logic [ADDR_W-1:0] slotStride;
  logic [ADDR_W-1:0] genBase;
  logic [ADDR_W-1:0] genOffset;
  logic [ADDR_W-1:0] target;
  logic [ADDR_W-1:0] resumeAddr;
  logic              anyTake;

  assign maskedPend = causePend & stIntMask;

  exc_vec_prio #(.LINES(LINES), .IDX_W(IDX_W)) uPrio (
    .lines(maskedPend),
    .idx  (hiIdx)
  );

  assign vecNum     = extCtrlMode ? causePend : LINES'(hiIdx);
  assign slotStride = ADDR_W'(vecSpacing) << SLOT_SHIFT;
  assign genBase    = stBev ? BOOT_GEN_BASE : (excBase & BASE_MASK);
  assign resumeAddr = reqInDelay ? (curPc - ADDR_W'(4)) : curPc;
  assign anyTake    = strobes.takeGen || strobes.takeErr || strobes.takeDbg;

  always_comb begin
    genOffset = OFS_GENERAL;
    if (strobes.isRefill) begin
      genOffset = OFS_REFILL;
    end else if (strobes.isCacheErr) begin
      genOffset = stBev ? OFS_CACHE_BEV : OFS_CACHE_RAM;
    end else if (strobes.isIntr && causeIv) begin
      if (stBev || vecSpacing == '0) genOffset = OFS_INTR;
      else genOffset = OFS_INTR + ADDR_W'(vecNum) * slotStride;
    end
  end

  always_comb begin
    if (strobes.takeErr)      target = ERR_VECTOR;
    else if (strobes.takeDbg) target = DBG_VECTOR;
    else                      target = genBase + genOffset;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      newPcValid  <= 1'b0;
      newPc       <= '0;
      epcOut      <= '0;
      errEpcOut   <= '0;
      dbgEpcOut   <= '0;
      excLevel    <= 1'b0;
      errLevel    <= 1'b0;
      bootVec     <= 1'b0;
      kernelMode  <= 1'b0;
      branchDelay <= 1'b0;
      dbgMode     <= 1'b0;
      excCode     <= '0;
    end else begin
      newPcValid <= anyTake;
      if (anyTake) newPc <= target;
      if (strobes.takeGen) begin
        excCode <= strobes.code;
        if (!stExl) begin
          epcOut      <= resumeAddr;
          branchDelay <= reqInDelay;
          excLevel    <= 1'b1;
          kernelMode  <= 1'b1;
        end
      end
      if (strobes.takeErr) begin
        errEpcOut  <= resumeAddr;
        errLevel   <= 1'b1;
        bootVec    <= 1'b1;
        kernelMode <= 1'b1;
        if (!stExl) branchDelay <= 1'b0;
      end
      if (strobes.takeDbg) begin
        dbgEpcOut  <= resumeAddr;
        dbgMode    <= 1'b1;
        kernelMode <= 1'b1;
        if (!stExl) branchDelay <= 1'b0;
      end
    end
  end

  // R11: a legal request produces the strobe on the next cycle
  p_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    anyTake |=> newPcValid);
  // R11: an idle cycle produces no strobe on the next cycle
  p_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !newPcValid);
  // R7: exception level already set freezes the saved return state
  p_exl_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.takeGen && stExl && !strobes.takeErr && !strobes.takeDbg)
      |=> ($stable(epcOut) && $stable(excLevel) && $stable(branchDelay)));
  // R6: level clear records the delay-adjusted return address
  p_resume_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.takeGen && !stExl)
      |=> (epcOut == ($past(reqInDelay) ? $past(curPc) - ADDR_W'(4) : $past(curPc))
           && excLevel && kernelMode));
  // R8: error class lands on the error vector
  p_err_vec_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.takeErr |=> (newPc == ERR_VECTOR && errLevel && bootVec));
  // R9: debug class lands on the debug vector
  p_dbg_vec_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.takeDbg |=> (newPc == DBG_VECTOR && dbgMode && kernelMode));
endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit
  import exc_vec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINES  = 8,
  parameter int SPC_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [4:0]        reqKind,
  input  logic              reqNoMatch,
  input  logic              reqInDelay,
  input  logic [ADDR_W-1:0] curPc,
  input  logic              stBev,
  input  logic              stExl,
  input  logic [LINES-1:0]  stIntMask,
  input  logic              causeIv,
  input  logic [LINES-1:0]  causePend,
  input  logic [SPC_W-1:0]  vecSpacing,
  input  logic              extCtrlMode,
  input  logic [ADDR_W-1:0] excBase,
  output logic              newPcValid,
  output logic [ADDR_W-1:0] newPc,
  output logic [ADDR_W-1:0] epcOut,
  output logic [ADDR_W-1:0] errEpcOut,
  output logic [ADDR_W-1:0] dbgEpcOut,
  output logic              excLevel,
  output logic              errLevel,
  output logic              bootVec,
  output logic              kernelMode,
  output logic              branchDelay,
  output logic              dbgMode,
  output logic [4:0]        excCode
);
  ctrlStrobes_t strobes;

  exc_vec_ctrl uCtrl (
    .reqValid  (reqValid),
    .reqKind   (reqKind),
    .reqNoMatch(reqNoMatch),
    .stExl     (stExl),
    .strobes   (strobes)
  );

  exc_vec_datapath #(.ADDR_W(ADDR_W), .LINES(LINES), .SPC_W(SPC_W)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .strobes    (strobes),
    .reqInDelay (reqInDelay),
    .curPc      (curPc),
    .stBev      (stBev),
    .stExl      (stExl),
    .stIntMask  (stIntMask),
    .causeIv    (causeIv),
    .causePend  (causePend),
    .vecSpacing (vecSpacing),
    .extCtrlMode(extCtrlMode),
    .excBase    (excBase),
    .newPcValid (newPcValid),
    .newPc      (newPc),
    .epcOut     (epcOut),
    .errEpcOut  (errEpcOut),
    .dbgEpcOut  (dbgEpcOut),
    .excLevel   (excLevel),
    .errLevel   (errLevel),
    .bootVec    (bootVec),
    .kernelMode (kernelMode),
    .branchDelay(branchDelay),
    .dbgMode    (dbgMode),
    .excCode    (excCode)
  );
endmodule

// File: tb/sim_exc_vector_unit.sv
module sim_exc_vector_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [4:0]  reqKind = '0;
  logic        reqNoMatch = 1'b0;
  logic        reqInDelay = 1'b0;
  logic [31:0] curPc = '0;
  logic        stBev = 1'b0;
  logic        stExl = 1'b0;
  logic [7:0]  stIntMask = '0;
  logic        causeIv = 1'b0;
  logic [7:0]  causePend = '0;
  logic [4:0]  vecSpacing = '0;
  logic        extCtrlMode = 1'b0;
  logic [31:0] excBase = '0;
  logic        newPcValid;
  logic [31:0] newPc, epcOut, errEpcOut, dbgEpcOut;
  logic        excLevel, errLevel, bootVec, kernelMode, branchDelay, dbgMode;
  logic [4:0]  excCode;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  exc_vector_unit u0 (.*);

  typedef struct packed {
    logic [4:0]  kind;
    logic        noMatch;
    logic        exl;
    logic        bev;
    logic        iv;
    logic        eic;
    logic [7:0]  pend;
    logic [7:0]  mask;
    logic [4:0]  spc;
    logic [31:0] base;
    logic [31:0] expPc;
    logic [4:0]  expCode;
    logic [3:0]  reqId;
  } vec_t;

  localparam int NVEC = 17;
  localparam vec_t TBL [NVEC] = '{
    '{5'd8,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 5'd0, 32'h8000_1234, 32'h8000_1180, 5'd8,  4'd1},
    '{5'd2,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 5'd0, 32'h8000_0000, 32'hBFC0_0200, 5'd2,  4'd2},
    '{5'd3,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 5'd0, 32'h8000_0000, 32'h8000_0180, 5'd3,  4'd2},
    '{5'd2,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 5'd0, 32'h8000_0000, 32'h8000_0180, 5'd2,  4'd2},
    '{5'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 8'hFF, 5'd3, 32'h8000_0000, 32'h8000_0180, 5'd0,  4'd3},
    '{5'd0,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h01, 8'hFF, 5'd4, 32'h8000_0000, 32'hBFC0_0400, 5'd0,  4'd3},
    '{5'd0,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h80, 8'hFF, 5'd0, 32'h8000_0000, 32'h8000_0200, 5'd0,  4'd3},
    '{5'd0,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'hA4, 8'h0F, 5'd1, 32'h8000_0000, 32'h8000_0240, 5'd0,  4'd4},
    '{5'd0,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'hA4, 8'hFF, 5'd2, 32'h8000_0000, 32'h8000_03C0, 5'd0,  4'd4},
    '{5'd0,  1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h05, 8'h00, 5'd1, 32'h8000_0000, 32'h8000_02A0, 5'd0,  4'd4},
    '{5'd30, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 5'd0, 32'h8000_0000, 32'hBFC0_0300, 5'd30, 4'd10},
    '{5'd30, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 5'd0, 32'h8000_0000, 32'hA000_0100, 5'd30, 4'd10},
    '{5'd13, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 5'd0, 32'h8000_0000, 32'h8000_0180, 5'd13, 4'd5},
    '{5'd20, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 5'd0, 32'h8000_0000, 32'h8000_0180, 5'd20, 4'd5},
    '{5'd19, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 5'd0, 32'h8000_0000, 32'h8000_0180, 5'd19, 4'd5},
    '{5'd28, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 5'd0, 32'h8000_0000, 32'hBFC0_0000, 5'd19, 4'd8},
    '{5'd31, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 5'd0, 32'h8000_0000, 32'hBFC0_0480, 5'd19, 4'd9}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive at the falling edge, let the rising edge capture, return at the next falling edge.
  task automatic issue(input logic [4:0] k, input logic [31:0] pc, input logic dly, input logic exl);
    reqKind = k; curPc = pc; reqInDelay = dly; stExl = exl; reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic checkReset();
    // R12: everything cleared
    chk("R12 newPcValid", 32'(newPcValid), 32'd0);
    chk("R12 newPc", newPc, 32'd0);
    chk("R12 epcOut", epcOut, 32'd0);
    chk("R12 errEpcOut", errEpcOut, 32'd0);
    chk("R12 dbgEpcOut", dbgEpcOut, 32'd0);
    chk("R12 status bits", {25'd0, excLevel, errLevel, bootVec, kernelMode, branchDelay, dbgMode, 1'b0}, 32'd0);
    chk("R12 excCode", 32'(excCode), 32'd0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R11 watchdog expired actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    doReset();
    checkReset();

    // Table walk covering R1 R2 R3 R4 R5 R8 R9 R10 and the R11 one-cycle strobe
    for (int i = 0; i < NVEC; i++) begin
      reqNoMatch = TBL[i].noMatch; stBev = TBL[i].bev; causeIv = TBL[i].iv;
      extCtrlMode = TBL[i].eic; causePend = TBL[i].pend; stIntMask = TBL[i].mask;
      vecSpacing = TBL[i].spc; excBase = TBL[i].base;
      issue(TBL[i].kind, 32'h0000_1000, 1'b0, TBL[i].exl);
      checks++;
      if (newPcValid !== 1'b1 || newPc !== TBL[i].expPc) begin
        errors++;
        $display("FAIL R%0d row %0d newPc actual=%h/%b expected=%h/1",
                 TBL[i].reqId, i, newPc, newPcValid, TBL[i].expPc);
      end
      checks++;
      if (excCode !== TBL[i].expCode) begin
        errors++;
        $display("FAIL R%0d row %0d excCode actual=%0d expected=%0d",
                 TBL[i].reqId, i, excCode, TBL[i].expCode);
      end
      @(negedge clk);
      chk("R11 strobe single cycle", 32'(newPcValid), 32'd0);
    end

    // Directed corner cases from a clean state
    stBev = 1'b0; excBase = 32'h8000_0000; causeIv = 1'b0; reqNoMatch = 1'b0;
    doReset();
    checkReset();

    // R6: level clear, delay slot
    issue(5'd4, 32'h0000_1000, 1'b1, 1'b0);
    chk("R6 epc delay", epcOut, 32'h0000_0FFC);
    chk("R6 branchDelay set", 32'(branchDelay), 32'd1);
    chk("R6 excLevel", 32'(excLevel), 32'd1);
    chk("R6 kernelMode", 32'(kernelMode), 32'd1);
    chk("R5 code adel", 32'(excCode), 32'd4);
    chk("R1 newPc", newPc, 32'h8000_0180);

    // R7: level set, state frozen but code and pc still produced
    issue(5'd5, 32'h0000_2000, 1'b0, 1'b1);
    chk("R7 epc held", epcOut, 32'h0000_0FFC);
    chk("R7 branchDelay held", 32'(branchDelay), 32'd1);
    chk("R7 code written", 32'(excCode), 32'd5);
    chk("R7 strobe", 32'(newPcValid), 32'd1);

    // R6: level clear again
    issue(5'd9, 32'h0000_3000, 1'b1, 1'b0);
    chk("R6 epc second", epcOut, 32'h0000_2FFC);

    // R8: soft reset clears the delay bit with level clear
    issue(5'd29, 32'h0000_4000, 1'b1, 1'b0);
    chk("R8 errEpc", errEpcOut, 32'h0000_3FFC);
    chk("R8 errLevel", 32'(errLevel), 32'd1);
    chk("R8 bootVec", 32'(bootVec), 32'd1);
    chk("R8 branchDelay cleared", 32'(branchDelay), 32'd0);
    chk("R8 newPc", newPc, 32'hBFC0_0000);
    chk("R5 code kept by error entry", 32'(excCode), 32'd9);

    // R9: debug entry with level set
    issue(5'd31, 32'h0000_5000, 1'b0, 1'b1);
    chk("R9 dbgEpc", dbgEpcOut, 32'h0000_5000);
    chk("R9 dbgMode", 32'(dbgMode), 32'd1);
    chk("R9 newPc", newPc, 32'hBFC0_0480);
    chk("R9 epc untouched", epcOut, 32'h0000_2FFC);

    // R11: illegal kind ignored
    issue(5'd17, 32'h0000_6000, 1'b1, 1'b0);
    chk("R11 illegal no strobe", 32'(newPcValid), 32'd0);
    chk("R11 illegal code kept", 32'(excCode), 32'd9);
    chk("R11 illegal epc kept", epcOut, 32'h0000_2FFC);
    chk("R11 illegal newPc kept", newPc, 32'hBFC0_0480);
    chk("R11 illegal branchDelay kept", 32'(branchDelay), 32'd0);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule